// File: doc/BRIEF.md
# ADC Result Slot Sequencer with Overrun Detection

This block is the digital back end of an analog-to-digital converter. It files each finished conversion into one of eight result slots and keeps a complete flag for every slot. It also keeps a sticky overrun flag that records when a slot was overwritten before software consumed it. The converter is modelled as a single-cycle done strobe that carries the result data. A sequence-start write arms a run with a programmable number of conversions. The run can be one pass or repeat on its own.

A 3-bit slot pointer names the slot that receives the next result. In the plain mode the pointer returns to slot 0 when a run is started and when it ends, so every pass refills the same slots from the bottom. In the queue mode the pointer is never reinitialised. Results then keep marching through the slots across runs and wrap from slot 7 to slot 0. Reading a slot clears its complete flag. Writing 1 to the overrun bit clears the overrun flag.

Top module: `adc_result_seq`

## Requirements
- R1: An accepted done strobe stores its data in the slot named by the pointer and sets that slot's complete flag at the same clock edge. Slot k occupies bits [k*DATA_W +: DATA_W] of result_o, and its flag is bit k of ccf_o.
- R2: Each accepted done strobe advances the pointer by one, and the pointer wraps from 7 to 0.
- R3: A start write clears every complete flag and the overrun flag. It latches the run length (values 1 to 8 are used as given, and 0 or any value above 8 means 8) and the repeat setting. With queue_mode_i low it sets the pointer to 0 in that cycle, and with queue_mode_i high it leaves the pointer unchanged. A done strobe in the same cycle as a start write is ignored.
- R4: A run ends when as many done strobes as its length have been accepted. At that edge the pointer goes to 0 when queue_mode_i is low and keeps advancing when it is high. Done strobes while no run is active change no result, flag or pointer.
- R5: When the repeat setting latched at start is 1, a run that ends starts again at once without clearing any flag, so the next done strobe is accepted.
- R6: A read strobe with index k clears complete flag k. If the same slot is written in that cycle, the flag stays set.
- R7: The overrun flag is set when an accepted done strobe targets a slot whose complete flag is set before that edge. This holds in both modes.
- R8: An overrun write with data 1 clears the overrun flag, and one with data 0 has no effect. When a set event and a clearing write fall in the same cycle, the flag ends up set.
- R9: After reset all slots hold 0, and all complete flags, the pointer and the overrun flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Sequence-start write strobe |
| seq_len_i | input | 4 | Run length, sampled at start |
| repeat_i | input | 1 | Restart the run automatically, sampled at start |
| queue_mode_i | input | 1 | 1 keeps the slot pointer across runs |
| done_i | input | 1 | Conversion-done strobe |
| done_data_i | input | DATA_W | Conversion result |
| rd_en_i | input | 1 | Result read strobe |
| rd_idx_i | input | 3 | Slot being read |
| ovr_we_i | input | 1 | Write strobe for the overrun bit |
| ovr_wdata_i | input | 1 | Value written to the overrun bit |
| result_o | output | 8*DATA_W | All result slots, slot k at bits [k*DATA_W +: DATA_W] |
| ccf_o | output | 8 | Per-slot complete flags |
| conv_cnt_o | output | 3 | Slot pointer |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
Every output is a register, so each result is due exactly one clock edge after the inputs that cause it. This covers stored data, flag changes, pointer moves and overrun set or clear. The bench drives all inputs on the falling edge. It updates its reference model right after the rising edge, from the inputs it drove and the model's earlier state, and compares every output on the next falling edge. Directed steps also check literal values at that same point, including the one-cycle collisions: start with done, read with write to the same slot, and overrun set with clear.

// File: rtl/adc_result_seq.sv
module adc_result_seq #(
  parameter int DATA_W = 10,
  parameter int NSLOT  = 8,
  localparam int IDX_W = $clog2(NSLOT),
  localparam int LEN_W = $clog2(NSLOT) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [LEN_W-1:0]        seq_len_i,
  input  logic                    repeat_i,
  input  logic                    queue_mode_i,
  input  logic                    done_i,
  input  logic [DATA_W-1:0]       done_data_i,
  input  logic                    rd_en_i,
  input  logic [IDX_W-1:0]        rd_idx_i,
  input  logic                    ovr_we_i,
  input  logic                    ovr_wdata_i,
  output logic [NSLOT*DATA_W-1:0] result_o,
  output logic [NSLOT-1:0]        ccf_o,
  output logic [IDX_W-1:0]        conv_cnt_o,
  output logic                    overrun_o
);

  logic [DATA_W-1:0] res_q [NSLOT];
  logic [NSLOT-1:0]  ccf_q;
  logic [IDX_W-1:0]  cc_q;
  logic [LEN_W-1:0]  len_q, dcnt_q;
  logic              active_q, rep_q, ovr_q;

  wire [LEN_W-1:0] len_dec = (seq_len_i == '0 || seq_len_i > LEN_W'(NSLOT)) ?
                             LEN_W'(NSLOT) : seq_len_i;
  wire acc  = done_i && active_q && !start_i;
  wire last = (dcnt_q == LEN_W'(len_q - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NSLOT; k++) res_q[k] <= '0;
      ccf_q    <= '0;
      cc_q     <= '0;
      len_q    <= LEN_W'(NSLOT);
      dcnt_q   <= '0;
      active_q <= 1'b0;
      rep_q    <= 1'b0;
      ovr_q    <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      len_q    <= len_dec;
      rep_q    <= repeat_i;
      dcnt_q   <= '0;
      ccf_q    <= '0;
      ovr_q    <= 1'b0;
      if (!queue_mode_i) cc_q <= '0;
    end else begin
      if (rd_en_i) ccf_q[rd_idx_i] <= 1'b0;
      if (ovr_we_i && ovr_wdata_i) ovr_q <= 1'b0;
      if (acc && ccf_q[cc_q]) ovr_q <= 1'b1;
      if (acc) begin
        res_q[cc_q] <= done_data_i;
        ccf_q[cc_q] <= 1'b1;
        if (last) begin
          dcnt_q   <= '0;
          active_q <= rep_q;
          cc_q     <= queue_mode_i ? IDX_W'(cc_q + 1'b1) : '0;
        end else begin
          dcnt_q <= LEN_W'(dcnt_q + 1'b1);
          cc_q   <= IDX_W'(cc_q + 1'b1);
        end
      end
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_flat
    assign result_o[g*DATA_W +: DATA_W] = res_q[g];
  end

  assign ccf_o      = ccf_q;
  assign conv_cnt_o = cc_q;
  assign overrun_o  = ovr_q;

  assert_slot_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ccf_o[$past(conv_cnt_o)]);
  assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (conv_cnt_o == IDX_W'($past(conv_cnt_o) + 1'b1)) || (conv_cnt_o == '0));
  assert_start_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (ccf_o == '0) && !overrun_o);
  assert_start_ptr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !queue_mode_i |=> conv_cnt_o == '0);
  assert_idle_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q && !start_i |=> $stable(result_o) && $stable(conv_cnt_o));
  assert_read_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i && !start_i && !(acc && conv_cnt_o == rd_idx_i) |=> !ccf_o[$past(rd_idx_i)]);
  assert_ovr_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && ccf_o[conv_cnt_o] |=> overrun_o);
  assert_ovr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o && !start_i && !(ovr_we_i && ovr_wdata_i) |=> overrun_o);

endmodule

// File: tb/adc_result_seq_bench.sv
module adc_result_seq_bench;
  localparam int DW = 10;
  localparam int NS = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, repeat_i = 0, queue_mode_i = 0, done_i = 0;
  logic rd_en_i = 0, ovr_we_i = 0, ovr_wdata_i = 0;
  logic [3:0] seq_len_i = 0;
  logic [DW-1:0] done_data_i = 0;
  logic [2:0] rd_idx_i = 0;
  logic [NS*DW-1:0] result_o;
  logic [NS-1:0] ccf_o;
  logic [2:0] conv_cnt_o;
  logic overrun_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [DW-1:0] m_res [NS];
  logic [NS-1:0] m_ccf;
  logic [2:0] m_cc;
  logic m_ovr, m_act, m_rep;
  int m_len, m_dc;

  adc_result_seq #(.DATA_W(DW), .NSLOT(NS)) u_adc_result_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .seq_len_i(seq_len_i),
    .repeat_i(repeat_i), .queue_mode_i(queue_mode_i), .done_i(done_i),
    .done_data_i(done_data_i), .rd_en_i(rd_en_i), .rd_idx_i(rd_idx_i),
    .ovr_we_i(ovr_we_i), .ovr_wdata_i(ovr_wdata_i), .result_o(result_o),
    .ccf_o(ccf_o), .conv_cnt_o(conv_cnt_o), .overrun_o(overrun_o));

  always #10 clk = ~clk;

  function automatic int dec_len(input logic [3:0] l);
    return (l == 0 || l > 8) ? 8 : int'(l);
  endfunction

  task automatic chk(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic model_step();
    logic acc, oset;
    acc = done_i && m_act && !start_i;
    if (start_i) begin
      m_act = 1; m_len = dec_len(seq_len_i); m_rep = repeat_i; m_dc = 0;
      m_ccf = '0; m_ovr = 0;
      if (!queue_mode_i) m_cc = 0;
    end else begin
      oset = acc && m_ccf[m_cc];
      if (rd_en_i) m_ccf[rd_idx_i] = 1'b0;
      if (ovr_we_i && ovr_wdata_i) m_ovr = 0;
      if (oset) m_ovr = 1;
      if (acc) begin
        m_res[m_cc] = done_data_i;
        m_ccf[m_cc] = 1'b1;
        if (m_dc == m_len - 1) begin
          m_dc = 0; m_act = m_rep;
          m_cc = queue_mode_i ? m_cc + 3'd1 : 3'd0;
        end else begin
          m_dc++; m_cc = m_cc + 3'd1;
        end
      end
    end
  endtask

  task automatic compare_all();
    for (int k = 0; k < NS; k++)
      chk($sformatf("R1 slot%0d", k), result_o[k*DW +: DW], m_res[k]);
    chk("R6 ccf", ccf_o, m_ccf);
    chk("R2 pointer", conv_cnt_o, m_cc);
    chk("R7 overrun", overrun_o, m_ovr);
  endtask

  task automatic cyc(input bit st, input logic [3:0] len, input bit rep, input bit q,
                     input bit dn, input logic [DW-1:0] d, input bit rd,
                     input logic [2:0] ri, input bit ow, input bit owd);
    start_i = st; seq_len_i = len; repeat_i = rep; queue_mode_i = q;
    done_i = dn; done_data_i = d; rd_en_i = rd; rd_idx_i = ri;
    ovr_we_i = ow; ovr_wdata_i = owd;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic done_n(input int n, input bit q, input logic [DW-1:0] base);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, q, 1, base + DW'(i), 0, 0, 0, 0);
  endtask

  initial begin
    int unsigned s;
    s = $urandom(32'h5eed);
    for (int k = 0; k < NS; k++) m_res[k] = '0;
    m_ccf = 0; m_cc = 0; m_ovr = 0; m_act = 0; m_rep = 0; m_len = 8; m_dc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 result", result_o, 0);
    chk("R9 ccf", ccf_o, 0);
    chk("R9 pointer", conv_cnt_o, 0);
    chk("R9 overrun", overrun_o, 0);

    cyc(0, 0, 0, 0, 1, 10'h155, 0, 0, 0, 0);
    chk("R4 idle done ignored ccf", ccf_o, 0);
    chk("R4 idle done ignored slot0", result_o[DW-1:0], 0);

    cyc(1, 4'd3, 0, 0, 1, 10'h3ff, 0, 0, 0, 0);
    chk("R3 start with done ccf", ccf_o, 0);
    chk("R3 start pointer", conv_cnt_o, 0);

    cyc(0, 0, 0, 0, 1, 10'h0a1, 0, 0, 0, 0);
    chk("R1 slot0 data", result_o[DW-1:0], 10'h0a1);
    chk("R1 ccf", ccf_o, 8'h01);
    chk("R2 pointer", conv_cnt_o, 1);
    done_n(2, 0, 10'h0b0);
    chk("R4 plain end pointer", conv_cnt_o, 0);
    chk("R4 plain end ccf", ccf_o, 8'h07);
    cyc(0, 0, 0, 0, 1, 10'h222, 0, 0, 0, 0);
    chk("R4 after end ignored", ccf_o, 8'h07);
    cyc(0, 0, 0, 0, 0, 0, 1, 3'd1, 0, 0);
    chk("R6 read clears", ccf_o, 8'h05);

    cyc(1, 4'd2, 0, 1, 0, 0, 0, 0, 0, 0);
    done_n(2, 1, 10'h100);
    chk("R4 queue end pointer", conv_cnt_o, 2);
    cyc(1, 4'd0, 1, 1, 0, 0, 0, 0, 0, 0);
    chk("R3 queue keeps pointer", conv_cnt_o, 2);
    done_n(6, 1, 10'h200);
    chk("R2 wrap", conv_cnt_o, 0);
    done_n(2, 1, 10'h210);
    chk("R7 full no overrun", overrun_o, 0);
    chk("R1 all flags", ccf_o, 8'hff);
    cyc(0, 0, 0, 1, 1, 10'h300, 0, 0, 0, 0);
    chk("R5 repeat accepts", conv_cnt_o, 3);
    chk("R7 overrun set", overrun_o, 1);
    cyc(0, 0, 0, 1, 0, 0, 0, 0, 1, 0);
    chk("R8 write zero no effect", overrun_o, 1);
    cyc(0, 0, 0, 1, 1, 10'h301, 0, 0, 1, 1);
    chk("R8 set beats clear", overrun_o, 1);
    cyc(0, 0, 0, 1, 0, 0, 0, 0, 1, 1);
    chk("R8 write one clears", overrun_o, 0);
    cyc(0, 0, 0, 1, 1, 10'h302, 1, 3'd4, 0, 0);
    chk("R6 write beats read", ccf_o, 8'hff);
    chk("R7 overrun again", overrun_o, 1);
    cyc(1, 4'd1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R3 start clears overrun", overrun_o, 0);
    chk("R3 start clears ccf", ccf_o, 0);

    for (int i = 0; i < 4000; i++) begin
      bit st;
      st = ($urandom_range(0, 19) == 0);
      cyc(st, 4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
          1'($urandom_range(0, 1)), ($urandom_range(0, 1) == 1),
          DW'($urandom), ($urandom_range(0, 2) == 0), 3'($urandom_range(0, 7)),
          ($urandom_range(0, 7) == 0), 1'($urandom_range(0, 1)));
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule